// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns one inter-processor interrupt request into the set of processor slots that should receive it. A request carries an addressing mode (physical or logical), a destination ID, a two-bit shorthand code, a lowest-priority delivery flag and the ID of the sending processor. The block holds a programmable local ID and an enable bit for each of `N_SLOTS` processor slots. It compares the request against every slot in parallel and returns a multi-hot target vector.

Requests are captured on `req_valid`. The target vector, a `res_done` pulse and four status flags appear one clock later. A new request can be taken on every cycle. Only physical addressing is decoded. IDs can be compared at the full `ID_W` width or in a narrow legacy mode that uses only the low four bits. An all-ones destination means broadcast. Three shorthands override the destination field. The block detects unsupported and illegal requests and requests that reach nobody. When a legal request asks for lowest-priority delivery, the block outputs the whole candidate set and raises a flag, so that a downstream arbiter can pick one target.

Top module: `ipi_dest_resolver`

## Requirements
- R1: Every cycle with `req_valid` high produces `res_done` high exactly one clock later. `res_done` is low in every cycle that does not follow a request, so back-to-back requests give back-to-back results.
- R2: `req_short` is encoded as 00 = none (use the destination), 01 = self, 10 = all, 11 = all except sender. Self selects the enabled slots whose ID equals `req_sender`. All selects every enabled slot. All except sender selects the enabled slots whose ID differs from `req_sender`. When the shorthand is not 00, `req_dest` and `req_logical` have no effect.
- R3: With shorthand 00, physical mode (`req_logical`=0) and full-width IDs (`legacy_ids`=0), a destination other than all-ones selects exactly the enabled slots whose ID equals `req_dest`.
- R4: With shorthand 00, physical mode and full-width IDs, a destination of all-ones (FFh at the default width) selects every enabled slot.
- R5: With `legacy_ids`=1, only bits 3:0 of the destination, the slot IDs and the sender ID are compared, and the upper bits are ignored. A destination of Fh in bits 3:0 is a broadcast, and 0h to Eh address single slots.
- R6: A request with shorthand 00 and `req_logical`=1 raises `res_unsupported` and produces an empty target vector.
- R7: A request with shorthand 00, physical mode, a broadcast destination and `req_lowpri`=1 raises `res_illegal` and produces an empty target vector.
- R8: A request with shorthand 00, physical mode and a non-broadcast destination that matches no enabled slot raises `res_nomatch`. At most one of `res_unsupported`, `res_illegal` and `res_nomatch` is high in any cycle.
- R9: A slot whose `slot_en` bit is 0 never appears in the target vector, including on broadcasts and shorthands.
- R10: A request with `req_lowpri`=1 that is neither unsupported nor illegal raises `res_arb_req` and outputs the full candidate set. `res_arb_req` is low otherwise.
- R11: After reset, and in any cycle that does not follow a request, the target vector and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_ids | input | 1 | 1 = compare only the low 4 ID bits |
| slot_en | input | N_SLOTS | Per-slot enable |
| slot_ids | input | N_SLOTS*ID_W | Local ID of each slot, slot 0 in the low bits |
| req_valid | input | 1 | Request strobe |
| req_logical | input | 1 | 1 = logical addressing (unsupported) |
| req_dest | input | ID_W | Destination ID |
| req_short | input | 2 | Shorthand code |
| req_lowpri | input | 1 | Lowest-priority delivery |
| req_sender | input | ID_W | ID of the sending processor |
| res_targets | output | N_SLOTS | Target vector |
| res_done | output | 1 | Result valid pulse |
| res_unsupported | output | 1 | Logical addressing requested |
| res_illegal | output | 1 | Lowest-priority broadcast requested |
| res_nomatch | output | 1 | Directed request reached no slot |
| res_arb_req | output | 1 | Downstream single-target arbitration needed |

## Verification
Every result of this block is due exactly one clock after the request edge. The vector, `res_done` and all four flags are registered on that same edge. The bench drives each request just after a falling edge and reads every output at the next falling edge, half a period after the capturing edge. It then drives the next request at once, so back-to-back acceptance is exercised throughout. Idle cycles are checked at the same point to confirm that the outputs clear one clock after the strobe drops.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
   typedef enum logic [1:0] {
      SH_NONE   = 2'b00,
      SH_SELF   = 2'b01,
      SH_ALL    = 2'b10,
      SH_OTHERS = 2'b11
   } shorthand_e;

   localparam int unsigned NARROW_ID_W = 4;
endpackage

// File: rtl/ipi_slot_cmp.sv
module ipi_slot_cmp #(
   parameter int unsigned ID_W  = 8,
   parameter int unsigned LEG_W = 4
) (
   input  logic [ID_W-1:0] slot_id,
   input  logic [ID_W-1:0] dest,
   input  logic [ID_W-1:0] sender,
   input  logic            legacy,
   output logic            hit_dest,
   output logic            hit_self
);
   logic [ID_W-1:0] cmp_mask;

   always_comb begin
      cmp_mask = '1;
      if (legacy) cmp_mask = ID_W'({LEG_W{1'b1}});
      hit_dest = ((slot_id ^ dest) & cmp_mask) == '0;
      hit_self = ((slot_id ^ sender) & cmp_mask) == '0;
   end
endmodule

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
   import ipi_dest_pkg::*;
#(
   parameter int unsigned N_SLOTS = 8,
   parameter int unsigned ID_W    = 8,
   parameter int unsigned LEG_W   = 4
) (
   input  logic               logical,
   input  logic [ID_W-1:0]    dest,
   input  shorthand_e         shorthand,
   input  logic               lowpri,
   input  logic               legacy,
   input  logic [N_SLOTS-1:0] en,
   input  logic [N_SLOTS-1:0] hit_dest,
   input  logic [N_SLOTS-1:0] hit_self,
   output logic [N_SLOTS-1:0] vec,
   output logic               unsup,
   output logic               illegal,
   output logic               nomatch,
   output logic               arb
);
   logic bcast;

   always_comb begin
      bcast   = legacy ? (&dest[LEG_W-1:0]) : (&dest);
      vec     = '0;
      unsup   = 1'b0;
      illegal = 1'b0;
      nomatch = 1'b0;
      unique case (shorthand)
         SH_SELF:   vec = en & hit_self;
         SH_ALL:    vec = en;
         SH_OTHERS: vec = en & ~hit_self;
         default: begin
            if (logical) begin
               unsup = 1'b1;
            end else if (bcast && lowpri) begin
               illegal = 1'b1;
            end else if (bcast) begin
               vec = en;
            end else begin
               vec     = en & hit_dest;
               nomatch = ~|(en & hit_dest);
            end
         end
      endcase
      arb = lowpri & ~unsup & ~illegal;
   end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
   import ipi_dest_pkg::*;
#(
   parameter int unsigned N_SLOTS = 8,
   parameter int unsigned ID_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      legacy_ids,
   input  logic [N_SLOTS-1:0]        slot_en,
   input  logic [N_SLOTS*ID_W-1:0]   slot_ids,
   input  logic                      req_valid,
   input  logic                      req_logical,
   input  logic [ID_W-1:0]           req_dest,
   input  logic [1:0]                req_short,
   input  logic                      req_lowpri,
   input  logic [ID_W-1:0]           req_sender,
   output logic [N_SLOTS-1:0]        res_targets,
   output logic                      res_done,
   output logic                      res_unsupported,
   output logic                      res_illegal,
   output logic                      res_nomatch,
   output logic                      res_arb_req
);
   localparam int unsigned LEG_W = NARROW_ID_W;

   if (ID_W < LEG_W) begin : g_bad_width
      $error("ID_W must be at least the narrow ID width");
   end
   if (N_SLOTS < 1) begin : g_bad_slots
      $error("N_SLOTS must be at least 1");
   end

   logic [N_SLOTS-1:0] hit_dest, hit_self, nxt_vec;
   logic nxt_unsup, nxt_illegal, nxt_nomatch, nxt_arb;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      ipi_slot_cmp #(.ID_W(ID_W), .LEG_W(LEG_W)) i_cmp (
         .slot_id  (slot_ids[s*ID_W +: ID_W]),
         .dest     (req_dest),
         .sender   (req_sender),
         .legacy   (legacy_ids),
         .hit_dest (hit_dest[s]),
         .hit_self (hit_self[s])
      );
   end

   ipi_dest_decode #(.N_SLOTS(N_SLOTS), .ID_W(ID_W), .LEG_W(LEG_W)) i_decode (
      .logical   (req_logical),
      .dest      (req_dest),
      .shorthand (shorthand_e'(req_short)),
      .lowpri    (req_lowpri),
      .legacy    (legacy_ids),
      .en        (slot_en),
      .hit_dest  (hit_dest),
      .hit_self  (hit_self),
      .vec       (nxt_vec),
      .unsup     (nxt_unsup),
      .illegal   (nxt_illegal),
      .nomatch   (nxt_nomatch),
      .arb       (nxt_arb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_targets     <= '0;
         res_done        <= 1'b0;
         res_unsupported <= 1'b0;
         res_illegal     <= 1'b0;
         res_nomatch     <= 1'b0;
         res_arb_req     <= 1'b0;
      end else begin
         res_done        <= req_valid;
         res_targets     <= req_valid ? nxt_vec : '0;
         res_unsupported <= req_valid & nxt_unsup;
         res_illegal     <= req_valid & nxt_illegal;
         res_nomatch     <= req_valid & nxt_nomatch;
         res_arb_req     <= req_valid & nxt_arb;
      end
   end

   assert_done_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_done);
   assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_done);
   assert_disabled_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((res_targets & ~$past(slot_en)) == '0));
   assert_unsup_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_unsupported |-> (res_targets == '0));
   assert_illegal_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> (res_targets == '0));
   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_unsupported, res_illegal, res_nomatch}));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !res_done |-> (res_targets == '0 && !res_arb_req && !res_nomatch));
endmodule

// File: tb/test_ipi_dest_resolver.sv
module test_ipi_dest_resolver;
   localparam int N = 8;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic legacy_ids = 1'b0;
   logic [N-1:0] slot_en = '0;
   logic [N*W-1:0] slot_ids = '0;
   logic req_valid = 1'b0, req_logical = 1'b0, req_lowpri = 1'b0;
   logic [W-1:0] req_dest = '0, req_sender = '0;
   logic [1:0] req_short = 2'b00;
   logic [N-1:0] res_targets;
   logic res_done, res_unsupported, res_illegal, res_nomatch, res_arb_req;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ipi_dest_resolver #(.N_SLOTS(N), .ID_W(W)) i_ipi_dest_resolver (.*);

   typedef struct packed {
      logic [N-1:0] vec;
      logic unsup, illegal, nomatch, arb;
   } exp_t;

   function automatic logic [W-1:0] msk(input logic [W-1:0] v, input logic leg);
      return leg ? (v & W'(4'hF)) : v;
   endfunction

   function automatic exp_t model(input logic leg, input logic [N-1:0] en,
                                  input logic [N*W-1:0] ids, input logic lg,
                                  input logic [W-1:0] d, input logic [1:0] sh,
                                  input logic lp, input logic [W-1:0] snd);
      exp_t e = '0;
      logic bc = (msk(d, leg) == msk('1, leg));
      for (int s = 0; s < N; s++) begin
         logic [W-1:0] id = ids[s*W +: W];
         logic me = (msk(id, leg) == msk(snd, leg));
         case (sh)
            2'b01: e.vec[s] = en[s] & me;
            2'b10: e.vec[s] = en[s];
            2'b11: e.vec[s] = en[s] & !me;
            default: if (!lg && !(bc && lp))
               e.vec[s] = en[s] & (bc || msk(id, leg) == msk(d, leg));
         endcase
      end
      if (sh == 2'b00) begin
         e.unsup   = lg;
         e.illegal = !lg && bc && lp;
         e.nomatch = !lg && !bc && (e.vec == '0);
      end
      e.arb = lp && !e.unsup && !e.illegal;
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_slot(input int s, input logic [W-1:0] id, input logic e);
      slot_ids[s*W +: W] = id;
      slot_en[s] = e;
   endtask

   task automatic req(input logic lg, input logic [W-1:0] d, input logic [1:0] sh,
                      input logic lp, input logic [W-1:0] snd);
      exp_t e = model(legacy_ids, slot_en, slot_ids, lg, d, sh, lp, snd);
      string vt;
      logic [N-1:0] en_now = slot_en;
      req_valid = 1'b1; req_logical = lg; req_dest = d;
      req_short = sh; req_lowpri = lp; req_sender = snd;
      @(negedge clk);
      if (sh != 2'b00) vt = "R2 vector";
      else if (lg) vt = "R6 vector";
      else if (e.illegal) vt = "R7 vector";
      else if (legacy_ids) vt = "R5 vector";
      else if (d == '1) vt = "R4 vector";
      else vt = "R3 vector";
      chk(vt, 32'(res_targets), 32'(e.vec));
      chk("R1 done", 32'(res_done), 32'd1);
      chk("R6 unsupported", 32'(res_unsupported), 32'(e.unsup));
      chk("R7 illegal", 32'(res_illegal), 32'(e.illegal));
      chk("R8 nomatch", 32'(res_nomatch), 32'(e.nomatch));
      chk("R10 arb", 32'(res_arb_req), 32'(e.arb));
      chk("R9 disabled", 32'(res_targets & ~en_now), 32'd0);
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle vector", 32'(res_targets), 32'd0);
      chk("R1 idle done", 32'(res_done), 32'd0);
      chk("R11 idle flags", 32'({res_unsupported, res_illegal, res_nomatch, res_arb_req}), 32'd0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk("R11 reset vector", 32'(res_targets), 32'd0);
      chk("R11 reset flags", 32'({res_done, res_unsupported, res_illegal, res_nomatch, res_arb_req}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int s = 0; s < N; s++) set_slot(s, W'(s + 8'h10 * s), 1'b1);
      // directed corners
      req(1'b0, 8'h22, 2'b00, 1'b0, 8'h00);      // R3 single match
      req(1'b0, 8'hFF, 2'b00, 1'b0, 8'h00);      // R4 broadcast
      req(1'b0, 8'hFF, 2'b00, 1'b1, 8'h00);      // R7 lowpri broadcast
      req(1'b0, 8'h33, 2'b00, 1'b1, 8'h00);      // R10 legal lowpri
      req(1'b1, 8'h22, 2'b00, 1'b0, 8'h00);      // R6 logical
      req(1'b1, 8'hFF, 2'b10, 1'b0, 8'h00);      // R2 shorthand overrides
      req(1'b0, 8'hFE, 2'b00, 1'b0, 8'h00);      // R8 nothing matches
      set_slot(2, 8'h22, 1'b0);
      req(1'b0, 8'h22, 2'b00, 1'b0, 8'h00);      // R9 disabled target
      req(1'b0, 8'hFF, 2'b00, 1'b0, 8'h00);      // R9 broadcast skips it
      req(1'b0, 8'h55, 2'b11, 1'b0, 8'h55);      // R2 all but sender
      req(1'b0, 8'h00, 2'b01, 1'b0, 8'h44);      // R2 self
      idle();
      legacy_ids = 1'b1;
      req(1'b0, 8'hA3, 2'b00, 1'b0, 8'h00);      // R5 upper bits ignored
      req(1'b0, 8'h0F, 2'b00, 1'b0, 8'h00);      // R5 narrow broadcast
      req(1'b0, 8'h2F, 2'b00, 1'b1, 8'h00);      // R5/R7 narrow broadcast lowpri
      idle();
      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] d;
         legacy_ids = 1'($urandom_range(0, 3) == 0);
         if (i % 25 == 0)
            for (int s = 0; s < N; s++)
               set_slot(s, W'($urandom_range(0, 15) | ($urandom_range(0, 1) ? 8'hF0 : 8'h00)),
                        1'($urandom_range(0, 4) != 0));
         case ($urandom_range(0, 3))
            0: d = '1;
            1: d = W'($urandom);
            default: d = slot_ids[$urandom_range(0, N - 1) * W +: W];
         endcase
         req(1'($urandom_range(0, 7) == 0), d, 2'($urandom),
             1'($urandom_range(0, 3) == 0), slot_ids[$urandom_range(0, N - 1) * W +: W]);
         if ($urandom_range(0, 9) == 0) idle();
      end
      idle();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule